// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This block holds the 256-byte internal data space of a small 8-bit controller together with its special-function registers, and performs one data-space operation per clock. The operation code selects a direct byte access, an access through a pointer register, a stack push or pop, a full or low-nibble exchange with the accumulator, or a single-bit move through the carry flag. The same 8-bit address means different storage depending on how it is used: above 7Fh a direct access reaches the register file, while an access through a pointer reaches the upper half of RAM.

The four working register banks live in the bottom 32 bytes of RAM; two bits of the status register choose the active bank, and direct addresses 00h to 07h follow that choice. A 128-bit field in RAM and every register at an address that is a multiple of 8 can be reached one bit at a time. All outputs are registered: the effect of an operation sampled at a clock edge is visible at the outputs right after that edge, and the next operation already sees the updated state.

Top module: `iram_access`

## Requirements
- R1: After reset, sp reads 07h, acc reads 00h, rdata reads 00h, and the registers B, PSW, P0, P1, DPL and DPH read 00h.
- R2: op 1 (direct read) and op 2 (direct write) with addr below 80h reach RAM; addr 00h to 07h map to RAM byte 8*bank + addr[2:0], where bank is bit 4:3 of PSW (register D0h); the other addresses below 80h map to themselves. A read returns the byte on rdata, a write returns wdata on rdata.
- R3: A direct access with addr 80h or above selects a register: P0 80h, SP 81h, DPL 82h, DPH 83h, P1 90h, PSW D0h, ACC E0h, B F0h; any other such address reads 00h and a write to it is ignored.
- R4: op 3 (pointer read) and op 4 (pointer write) use as address the RAM byte 8*bank + addr[0]; every address, including 80h to FFh, reaches RAM and never a register, and sp and acc keep their values.
- R5: op 5 (push) adds one to SP modulo 256, then stores the direct operand at addr (read before the push) into RAM at the new SP; rdata returns the pushed byte.
- R6: op 6 (pop) moves RAM at SP to the direct destination addr and subtracts one from SP modulo 256; rdata returns the popped byte; when the destination is 81h, SP ends up holding the popped byte.
- R7: op 7 swaps acc with the direct operand at addr; rdata returns the operand's old value.
- R8: op 8 swaps bits 3:0 of acc with bits 3:0 of the pointer operand (address as in R4); bits 7:4 of both stay; rdata returns the operand's old value.
- R9: op 9 (bit read) with bit address addr below 80h reads RAM byte 20h + addr[7:3], bit addr[2:0]; from 80h up it reads register byte addr with bits 2:0 cleared, bit addr[2:0]; the bit is copied into the carry (PSW bit 7) and rdata returns 0000000 followed by the bit.
- R10: op 10 (bit write) stores the carry into the addressed bit (mapping as R9) in a single cycle, leaves the other seven bits of that byte unchanged, and is ignored when the byte is an unimplemented register; rdata returns the old bit.
- R11: op 0 and the unused codes 11 to 15 change no state and rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op | input | 4 | Operation code (0 idle, 1 to 10 as in the requirements) |
| addr | input | 8 | Direct address, bit address, or pointer select in bit 0 |
| wdata | input | 8 | Write data for direct and pointer writes |
| rdata | output | 8 | Result byte of the last operation |
| sp | output | 8 | Stack pointer |
| acc | output | 8 | Accumulator |

## Verification
The hardest state to reach from the ports is the one where an address above 7Fh must mean RAM in one operation and a register in the next, because the upper RAM half can only be written through a pointer that itself sits in a bank chosen by the status register. The stimulus first fills all 256 bytes, the upper half by loading R0 and writing through it, then alternates direct and pointer accesses to the same upper address under different banks, and finally pushes the stack pointer across FFh and pops into the stack pointer itself. A long random run, with status and stack pointer writes mixed in, then lets bank changes, wrap-around and bit moves into live registers collide.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NSFR = 8;
  localparam logic [7:0] SP_RESET = 8'h07;
  localparam logic [7:0] BIT_RAM_BASE = 8'h20;

  localparam logic [7:0] ADR_P0  = 8'h80;
  localparam logic [7:0] ADR_SP  = 8'h81;
  localparam logic [7:0] ADR_DPL = 8'h82;
  localparam logic [7:0] ADR_DPH = 8'h83;
  localparam logic [7:0] ADR_P1  = 8'h90;
  localparam logic [7:0] ADR_PSW = 8'hD0;
  localparam logic [7:0] ADR_ACC = 8'hE0;
  localparam logic [7:0] ADR_B   = 8'hF0;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_RDD  = 4'd1,
    OP_WRD  = 4'd2,
    OP_RDI  = 4'd3,
    OP_WRI  = 4'd4,
    OP_PUSH = 4'd5,
    OP_POP  = 4'd6,
    OP_XCH  = 4'd7,
    OP_XCHD = 4'd8,
    OP_BRD  = 4'd9,
    OP_BWR  = 4'd10
  } iram_op_e;

  function automatic logic [7:0] sfr_slot_addr(input int k);
    case (k)
      0: return ADR_P0;
      1: return ADR_SP;
      2: return ADR_DPL;
      3: return ADR_DPH;
      4: return ADR_P1;
      5: return ADR_PSW;
      6: return ADR_ACC;
      default: return ADR_B;
    endcase
  endfunction
endpackage

// File: rtl/iram_bytes.sv
module iram_bytes #(
  parameter int W = 8,
  parameter int A = 8,
  parameter int D = 256
) (
  input  logic         clk,
  input  logic         we,
  input  logic [A-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [A-1:0] raddr_p,
  output logic [W-1:0] rdata_p,
  input  logic [A-1:0] raddr_d,
  output logic [W-1:0] rdata_d
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_p = mem[raddr_p];
  assign rdata_d = mem[raddr_d];
endmodule

// File: rtl/iram_sfr.sv
module iram_sfr
  import iram_pkg::*;
#(
  parameter int W = DW,
  parameter int A = AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [A-1:0] raddr,
  output logic [W-1:0] rdata,
  input  logic         we,
  input  logic [A-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic         sp_we,
  input  logic [W-1:0] sp_wdata,
  input  logic         acc_we,
  input  logic [W-1:0] acc_wdata,
  input  logic         cy_we,
  input  logic         cy_wdata,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] acc_q,
  output logic [1:0]   bank_q,
  output logic         cy_q
);
  logic [NSFR*W-1:0] slot_flat;
  logic [NSFR-1:0]   hit;

  for (genvar k = 0; k < NSFR; k++) begin : g_slot
    localparam logic [A-1:0] SLOT = A'(sfr_slot_addr(k));
    localparam logic [W-1:0] RST  = (SLOT == A'(ADR_SP)) ? W'(SP_RESET) : '0;
    logic [W-1:0] q;
    logic [W-1:0] d;
    logic         en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (SLOT == A'(ADR_SP) && sp_we) begin
        d  = sp_wdata;
        en = 1'b1;
      end
      if (SLOT == A'(ADR_ACC) && acc_we) begin
        d  = acc_wdata;
        en = 1'b1;
      end
      if (SLOT == A'(ADR_PSW) && cy_we) begin
        d[W-1] = cy_wdata;
        en     = 1'b1;
      end
      if (we && waddr == SLOT) begin
        d  = wdata;
        en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST;
      end else if (en) begin
        q <= d;
      end
    end

    assign slot_flat[k*W +: W] = q;
    assign hit[k] = (raddr == SLOT);

    if (SLOT == A'(ADR_SP)) begin : g_sp
      assign sp_q = q;
    end
    if (SLOT == A'(ADR_ACC)) begin : g_acc
      assign acc_q = q;
    end
    if (SLOT == A'(ADR_PSW)) begin : g_psw
      assign bank_q = q[4:3];
      assign cy_q   = q[W-1];
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NSFR; k++) begin
      if (hit[k]) begin
        rdata = slot_flat[k*W +: W];
      end
    end
  end
endmodule

// File: rtl/iram_bitmap.sv
module iram_bitmap
  import iram_pkg::*;
#(
  parameter int A  = AW,
  parameter int BW = 3
) (
  input  logic [A-1:0]  bit_addr,
  output logic          in_sfr,
  output logic [A-1:0]  byte_addr,
  output logic [BW-1:0] bit_idx
);
  logic [A-BW-1:0] group;

  assign group   = bit_addr[A-1:BW];
  assign in_sfr  = bit_addr[A-1];
  assign bit_idx = bit_addr[BW-1:0];

  always_comb begin
    if (in_sfr) begin
      byte_addr = {group, {BW{1'b0}}};
    end else begin
      byte_addr = A'(BIT_RAM_BASE) + A'(group);
    end
  end
endmodule

// File: rtl/iram_access.sv
module iram_access
  import iram_pkg::*;
#(
  parameter int W = DW,
  parameter int A = AW,
  parameter int D = DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [A-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] sp,
  output logic [W-1:0] acc
);
  localparam int BW = $clog2(W);
  localparam int HW = W / 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  iram_op_e opc;
  assign opc = iram_op_e'(op);

  logic [1:0]   bank;
  logic         cy;
  logic [A-1:0] ptr_slot;
  logic [A-1:0] dir_map;
  logic [W-1:0] ram_p;
  logic [W-1:0] ram_d;
  logic [W-1:0] sfr_rdata;
  logic [A-1:0] ptr;
  logic [W-1:0] sp_inc;
  logic [W-1:0] sp_dec;

  assign ptr_slot = A'({bank, 2'b00, addr[0]});
  assign dir_map  = (addr[A-1:BW] == '0) ? A'({bank, addr[BW-1:0]}) : addr;
  assign ptr      = A'(ram_p);
  assign sp_inc   = sp + W'(1);
  assign sp_dec   = sp - W'(1);

  logic          bm_sfr;
  logic [A-1:0]  bm_byte;
  logic [BW-1:0] bm_bit;

  iram_bitmap #(.A(A), .BW(BW)) u_bitmap (
    .bit_addr (addr),
    .in_sfr   (bm_sfr),
    .byte_addr(bm_byte),
    .bit_idx  (bm_bit)
  );

  // operand selection
  logic [A-1:0] ram_raddr;
  logic [A-1:0] sfr_raddr;
  logic         opnd_sfr;
  logic [W-1:0] opnd;
  logic         sel_bit;
  logic [W-1:0] bit_merged;

  always_comb begin
    ram_raddr = dir_map;
    sfr_raddr = addr;
    opnd_sfr  = addr[A-1];
    case (opc)
      OP_RDI, OP_WRI, OP_XCHD: begin
        ram_raddr = ptr;
        opnd_sfr  = 1'b0;
      end
      OP_POP: begin
        ram_raddr = A'(sp);
        opnd_sfr  = 1'b0;
      end
      OP_BRD, OP_BWR: begin
        ram_raddr = bm_byte;
        sfr_raddr = bm_byte;
        opnd_sfr  = bm_sfr;
      end
      default: ;
    endcase
  end

  assign opnd    = opnd_sfr ? sfr_rdata : ram_d;
  assign sel_bit = opnd[bm_bit];

  always_comb begin
    bit_merged         = opnd;
    bit_merged[bm_bit] = cy;
  end

  // write and result selection
  logic         ram_we;
  logic [A-1:0] ram_waddr;
  logic [W-1:0] ram_wdata;
  logic         sfr_we;
  logic [A-1:0] sfr_waddr;
  logic [W-1:0] sfr_wdata;
  logic         dir_we;
  logic [W-1:0] dir_wdata;
  logic         sp_we;
  logic [W-1:0] sp_wd;
  logic         acc_we;
  logic [W-1:0] acc_wd;
  logic         cy_we;
  logic         cy_wd;
  logic         rdata_en;
  logic [W-1:0] rdata_d;
  logic [W-1:0] rdata_q;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = dir_map;
    ram_wdata = wdata;
    sfr_we    = 1'b0;
    sfr_waddr = addr;
    sfr_wdata = wdata;
    dir_we    = 1'b0;
    dir_wdata = wdata;
    sp_we     = 1'b0;
    sp_wd     = sp;
    acc_we    = 1'b0;
    acc_wd    = acc;
    cy_we     = 1'b0;
    cy_wd     = 1'b0;
    rdata_en  = 1'b1;
    rdata_d   = opnd;
    case (opc)
      OP_RDD, OP_RDI: ;
      OP_WRD: begin
        dir_we  = 1'b1;
        rdata_d = wdata;
      end
      OP_WRI: begin
        ram_we    = 1'b1;
        ram_waddr = ptr;
        rdata_d   = wdata;
      end
      OP_PUSH: begin
        ram_we    = 1'b1;
        ram_waddr = A'(sp_inc);
        ram_wdata = opnd;
        sp_we     = 1'b1;
        sp_wd     = sp_inc;
      end
      OP_POP: begin
        dir_we    = 1'b1;
        dir_wdata = opnd;
        sp_we     = 1'b1;
        sp_wd     = sp_dec;
      end
      OP_XCH: begin
        dir_we    = 1'b1;
        dir_wdata = acc;
        acc_we    = 1'b1;
        acc_wd    = opnd;
      end
      OP_XCHD: begin
        ram_we    = 1'b1;
        ram_waddr = ptr;
        ram_wdata = {opnd[W-1:HW], acc[HW-1:0]};
        acc_we    = 1'b1;
        acc_wd    = {acc[W-1:HW], opnd[HW-1:0]};
      end
      OP_BRD: begin
        cy_we   = 1'b1;
        cy_wd   = sel_bit;
        rdata_d = W'(sel_bit);
      end
      OP_BWR: begin
        rdata_d = W'(sel_bit);
        if (bm_sfr) begin
          sfr_we    = 1'b1;
          sfr_waddr = bm_byte;
          sfr_wdata = bit_merged;
        end else begin
          ram_we    = 1'b1;
          ram_waddr = bm_byte;
          ram_wdata = bit_merged;
        end
      end
      default: rdata_en = 1'b0;
    endcase
    if (dir_we) begin
      if (addr[A-1]) begin
        sfr_we    = 1'b1;
        sfr_waddr = addr;
        sfr_wdata = dir_wdata;
      end else begin
        ram_we    = 1'b1;
        ram_waddr = dir_map;
        ram_wdata = dir_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  iram_bytes #(.W(W), .A(A), .D(D)) u_bytes (
    .clk    (clk),
    .we     (ram_we & rst_q_n),
    .waddr  (ram_waddr),
    .wdata  (ram_wdata),
    .raddr_p(ptr_slot),
    .rdata_p(ram_p),
    .raddr_d(ram_raddr),
    .rdata_d(ram_d)
  );

  iram_sfr #(.W(W), .A(A)) u_sfr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .raddr    (sfr_raddr),
    .rdata    (sfr_rdata),
    .we       (sfr_we),
    .waddr    (sfr_waddr),
    .wdata    (sfr_wdata),
    .sp_we    (sp_we),
    .sp_wdata (sp_wd),
    .acc_we   (acc_we),
    .acc_wdata(acc_wd),
    .cy_we    (cy_we),
    .cy_wdata (cy_wd),
    .sp_q     (sp),
    .acc_q    (acc),
    .bank_q   (bank),
    .cy_q     (cy)
  );

  assign rdata = rdata_q;
endmodule

// File: rtl/iram_access_chk.sv
module iram_access_chk
  import iram_pkg::*;
#(
  parameter int W = DW,
  parameter int A = AW
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic [A-1:0] addr,
  input logic [W-1:0] rdata,
  input logic [W-1:0] sp,
  input logic [W-1:0] acc
);
  // R5: a push raises the stack pointer by one
  a_r5_push_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> (sp == W'($past(sp) + W'(1))));

  // R6: a pop to anything but SP lowers the stack pointer by one
  a_r6_pop_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && addr != A'(ADR_SP)) |=> (sp == W'($past(sp) - W'(1))));

  // R11: idle codes keep every output
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP || op > OP_BWR) |=> ($stable(sp) && $stable(acc) && $stable(rdata)));

  // R8: nibble exchange keeps the accumulator high half
  a_r8_high_nibble_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHD) |=> (acc[W-1:W/2] == $past(acc[W-1:W/2])));

  // R9: a bit read returns one bit and leaves SP and ACC
  a_r9_bit_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BRD) |=> (rdata[W-1:1] == '0 && $stable(sp) && $stable(acc)));

  // R4: pointer accesses never reach the register file
  a_r4_pointer_spares_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RDI || op == OP_WRI) |=> ($stable(sp) && $stable(acc)));
endmodule

bind iram_access iram_access_chk #(.W(W), .A(A)) u_chk (
  .clk  (clk),
  .rst_n(rst_q_n),
  .op   (op),
  .addr (addr),
  .rdata(rdata),
  .sp   (sp),
  .acc  (acc)
);

// File: tb/test_iram_access.sv
module test_iram_access;
  import iram_pkg::*;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] sp;
  logic [7:0] acc;

  iram_access i_iram_access (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata),
    .sp   (sp),
    .acc  (acc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;
  bit done;

  // behavioural reference state
  logic [7:0] mram [256];
  logic [7:0] msfr [256];
  bit         mimpl [256];
  logic [7:0] m_rd;

  task automatic m_reset();
    for (int i = 0; i < 256; i++) begin
      msfr[i]  = 8'h00;
      mimpl[i] = 1'b0;
      mram[i]  = 8'h00;
    end
    mimpl[8'h80] = 1'b1; mimpl[8'h81] = 1'b1; mimpl[8'h82] = 1'b1; mimpl[8'h83] = 1'b1;
    mimpl[8'h90] = 1'b1; mimpl[8'hD0] = 1'b1; mimpl[8'hE0] = 1'b1; mimpl[8'hF0] = 1'b1;
    msfr[8'h81] = 8'h07;
    m_rd = 8'h00;
  endtask

  function automatic logic [7:0] m_dmap(logic [7:0] a);
    if (a < 8'h08) return {3'b000, msfr[8'hD0][4:3], a[2:0]};
    return a;
  endfunction

  function automatic logic [7:0] m_dir_rd(logic [7:0] a);
    if (a[7]) return mimpl[a] ? msfr[a] : 8'h00;
    return mram[m_dmap(a)];
  endfunction

  task automatic m_dir_wr(logic [7:0] a, logic [7:0] v);
    if (a[7]) begin
      if (mimpl[a]) msfr[a] = v;
    end else begin
      mram[m_dmap(a)] = v;
    end
  endtask

  task automatic m_step(logic [3:0] o, logic [7:0] a, logic [7:0] d);
    logic [7:0] sp0, acc0, psw0, v, p, bb;
    int bi;
    sp0  = msfr[8'h81];
    acc0 = msfr[8'hE0];
    psw0 = msfr[8'hD0];
    p    = mram[{3'b000, psw0[4:3], 2'b00, a[0]}];
    case (o)
      OP_RDD: m_rd = m_dir_rd(a);
      OP_WRD: begin m_dir_wr(a, d); m_rd = d; end
      OP_RDI: m_rd = mram[p];
      OP_WRI: begin mram[p] = d; m_rd = d; end
      OP_PUSH: begin
        v = m_dir_rd(a);
        msfr[8'h81] = sp0 + 8'd1;
        mram[sp0 + 8'd1] = v;
        m_rd = v;
      end
      OP_POP: begin
        v = mram[sp0];
        msfr[8'h81] = sp0 - 8'd1;
        m_dir_wr(a, v);
        m_rd = v;
      end
      OP_XCH: begin
        v = m_dir_rd(a);
        msfr[8'hE0] = v;
        m_dir_wr(a, acc0);
        m_rd = v;
      end
      OP_XCHD: begin
        v = mram[p];
        mram[p] = {v[7:4], acc0[3:0]};
        msfr[8'hE0] = {acc0[7:4], v[3:0]};
        m_rd = v;
      end
      OP_BRD, OP_BWR: begin
        bi = int'(a[2:0]);
        if (a < 8'h80) begin
          bb = 8'h20 + (a >> 3);
          v  = mram[bb];
        end else begin
          bb = a & 8'hF8;
          v  = mimpl[bb] ? msfr[bb] : 8'h00;
        end
        m_rd = {7'b0, v[bi]};
        if (o == OP_BRD) begin
          msfr[8'hD0][7] = v[bi];
        end else begin
          v[bi] = psw0[7];
          if (a < 8'h80) mram[bb] = v;
          else if (mimpl[bb]) msfr[bb] = v;
        end
      end
      default: ;
    endcase
  endtask

  function automatic string req_tag(logic [3:0] o, logic [7:0] a);
    case (o)
      OP_RDD, OP_WRD: return a[7] ? "R3" : "R2";
      OP_RDI, OP_WRI: return "R4";
      OP_PUSH: return "R5";
      OP_POP:  return "R6";
      OP_XCH:  return "R7";
      OP_XCHD: return "R8";
      OP_BRD:  return "R9";
      OP_BWR:  return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic do_op(logic [3:0] o, logic [7:0] a, logic [7:0] d, string tag);
    string t;
    t = (tag == "") ? req_tag(o, a) : tag;
    op    = o;
    addr  = a;
    wdata = d;
    m_step(o, a, d);
    @(posedge clk);
    #2;
    n_chk++;
    if (rdata !== m_rd || sp !== msfr[8'h81] || acc !== msfr[8'hE0]) begin
      n_fail++;
      $display("FAIL %s op=%0d addr=%02h rdata/sp/acc actual %02h/%02h/%02h expected %02h/%02h/%02h",
               t, o, a, rdata, sp, acc, m_rd, msfr[8'h81], msfr[8'hE0]);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R11 actual=still running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] ro;
    int rsel;
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    op = OP_NOP;
    addr = 8'h00;
    wdata = 8'h00;
    m_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;

    // R1: reset values at the ports and through direct reads
    n_chk++;
    if (sp !== 8'h07 || acc !== 8'h00 || rdata !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 rdata/sp/acc actual %02h/%02h/%02h expected 00/07/00", rdata, sp, acc);
    end
    do_op(OP_RDD, 8'hF0, 8'h00, "R1");
    do_op(OP_RDD, 8'hD0, 8'h00, "R1");
    do_op(OP_RDD, 8'h80, 8'h00, "R1");
    do_op(OP_RDD, 8'h90, 8'h00, "R1");
    do_op(OP_RDD, 8'h82, 8'h00, "R1");
    do_op(OP_RDD, 8'h83, 8'h00, "R1");
    do_op(OP_RDD, 8'h81, 8'h00, "R1");

    // fill RAM: lower half directly (R2), upper half through R0 (R4)
    for (int a = 0; a < 128; a++) do_op(OP_WRD, 8'(a), 8'(a) ^ 8'h5A, "");
    for (int a = 128; a < 256; a++) begin
      do_op(OP_WRD, 8'h00, 8'(a), "");
      do_op(OP_WRI, 8'h00, 8'(a) ^ 8'hA5, "");
    end

    // R2: bank aliasing of 00h-07h
    do_op(OP_RDD, 8'h30, 8'h00, "R2");
    do_op(OP_WRD, 8'hD0, 8'h08, "R2");
    do_op(OP_RDD, 8'h03, 8'h00, "R2");
    do_op(OP_WRD, 8'h05, 8'h77, "R2");
    do_op(OP_RDD, 8'h0D, 8'h00, "R2");
    do_op(OP_WRD, 8'hD0, 8'h18, "R2");
    do_op(OP_RDD, 8'h07, 8'h00, "R2");

    // R3: registers and an unimplemented address
    do_op(OP_WRD, 8'hF0, 8'h3C, "R3");
    do_op(OP_RDD, 8'hF0, 8'h00, "R3");
    do_op(OP_WRD, 8'hA0, 8'h99, "R3");
    do_op(OP_RDD, 8'hA0, 8'h00, "R3");
    do_op(OP_WRD, 8'hE0, 8'h81, "R3");

    // R4: upper half through a pointer is RAM, directly it is registers
    do_op(OP_WRD, 8'hD0, 8'h00, "R4");
    do_op(OP_WRD, 8'h01, 8'hC5, "R4");
    do_op(OP_RDI, 8'h01, 8'h00, "R4");
    do_op(OP_WRI, 8'h01, 8'h42, "R4");
    do_op(OP_RDD, 8'hC5, 8'h00, "R4");
    do_op(OP_RDI, 8'h01, 8'h00, "R4");
    do_op(OP_WRD, 8'hD0, 8'h18, "R4");
    do_op(OP_WRD, 8'h00, 8'hE0, "R4");
    do_op(OP_WRI, 8'h00, 8'h11, "R4");
    do_op(OP_RDD, 8'hE0, 8'h00, "R4");

    // R5 / R6: stack order, wrap-around, pop into SP
    do_op(OP_WRD, 8'hD0, 8'h00, "R5");
    do_op(OP_WRD, 8'h81, 8'h40, "R5");
    do_op(OP_WRD, 8'hE0, 8'hAB, "R5");
    do_op(OP_PUSH, 8'hE0, 8'h00, "R5");
    do_op(OP_PUSH, 8'hF0, 8'h00, "R5");
    do_op(OP_POP, 8'h33, 8'h00, "R6");
    do_op(OP_POP, 8'h34, 8'h00, "R6");
    do_op(OP_RDD, 8'h33, 8'h00, "R6");
    do_op(OP_WRD, 8'h81, 8'hFF, "R5");
    do_op(OP_PUSH, 8'hE0, 8'h00, "R5");
    do_op(OP_RDD, 8'h00, 8'h00, "R5");
    do_op(OP_POP, 8'h50, 8'h00, "R6");
    do_op(OP_WRD, 8'h60, 8'h25, "R6");
    do_op(OP_WRD, 8'h81, 8'h60, "R6");
    do_op(OP_POP, 8'h81, 8'h00, "R6");
    do_op(OP_PUSH, 8'h81, 8'h00, "R5");

    // R7: full exchange with RAM, B and ACC itself
    do_op(OP_WRD, 8'hE0, 8'h12, "R7");
    do_op(OP_WRD, 8'h45, 8'h9E, "R7");
    do_op(OP_XCH, 8'h45, 8'h00, "R7");
    do_op(OP_RDD, 8'h45, 8'h00, "R7");
    do_op(OP_XCH, 8'hF0, 8'h00, "R7");
    do_op(OP_XCH, 8'hE0, 8'h00, "R7");

    // R8: low nibble exchange through R0
    do_op(OP_WRD, 8'h00, 8'h70, "R8");
    do_op(OP_WRD, 8'h70, 8'hC3, "R8");
    do_op(OP_WRD, 8'hE0, 8'h5A, "R8");
    do_op(OP_XCHD, 8'h00, 8'h00, "R8");
    do_op(OP_RDI, 8'h00, 8'h00, "R8");

    // R9: bit reads from the RAM field and registers into carry
    do_op(OP_WRD, 8'h2F, 8'h80, "R9");
    do_op(OP_BRD, 8'h7F, 8'h00, "R9");
    do_op(OP_RDD, 8'hD0, 8'h00, "R9");
    do_op(OP_BRD, 8'h78, 8'h00, "R9");
    do_op(OP_RDD, 8'hD0, 8'h00, "R9");
    do_op(OP_BRD, 8'hE3, 8'h00, "R9");
    do_op(OP_WRD, 8'h80, 8'h80, "R9");
    do_op(OP_BRD, 8'h87, 8'h00, "R9");

    // R10: bit writes from carry
    do_op(OP_WRD, 8'hD0, 8'h80, "R10");
    do_op(OP_BWR, 8'h00, 8'h00, "R10");
    do_op(OP_RDD, 8'h20, 8'h00, "R10");
    do_op(OP_BWR, 8'hF5, 8'h00, "R10");
    do_op(OP_RDD, 8'hF0, 8'h00, "R10");
    do_op(OP_BWR, 8'h8F, 8'h00, "R10");
    do_op(OP_RDD, 8'h88, 8'h00, "R10");
    do_op(OP_WRD, 8'hE0, 8'hFF, "R10");
    do_op(OP_WRD, 8'hD0, 8'h00, "R10");
    do_op(OP_BWR, 8'hE7, 8'h00, "R10");

    // R11: idle and unused codes
    do_op(OP_RDD, 8'h20, 8'h00, "R11");
    do_op(OP_NOP, 8'h20, 8'hFF, "R11");
    do_op(4'hF, 8'hE0, 8'h00, "R11");
    do_op(4'd11, 8'h81, 8'h55, "R11");
    do_op(OP_RDD, 8'h81, 8'h00, "R11");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      rsel = $urandom_range(0, 11);
      ro = (rsel == 11) ? 4'hF : 4'(rsel);
      do_op(ro, 8'($urandom), 8'($urandom), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule